// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit sits next to one processor core. It counts time, compares that count against a programmable deadline and raises two interrupt-pending lines: one for the timer and one for software. The time count and a companion cycle count advance by one on every cycle in which the tick input is high. The compare register holds the deadline. The software bit is a flag that firmware sets or clears with a store.

Firmware reaches the unit through a small register bus. Each access gives a window offset, an access size in bytes, write data and a write strobe. Read data is returned in the same cycle. The timer-pending line is set only when the deadline lies strictly below the current time. A deadline of zero keeps the line low. The line is recomputed on every tick. It is also recomputed on every accepted write, so a new deadline takes effect with no wait for the next tick. A write that misses a register, or that uses a size the register does not take, changes nothing and raises a one-cycle error.

Top module: `core_timer_unit`

## Requirements
- R1: A cycle with `tick_i` high raises both the time count and `cycles_o` by exactly one. A cycle with `tick_i` low leaves both unchanged.
- R2: After any clock edge, `timer_irq_o` is high exactly when the compare value is nonzero and is strictly less than the time count, using an unsigned comparison. Equal values leave it low.
- R3: A compare value of zero keeps `timer_irq_o` low for every time count, including across ticks.
- R4: An accepted write to the compare register or to the software register re-evaluates `timer_irq_o` at the same edge, even when no tick occurs.
- R5: A write to offset 0x0000 with size 4 or 8 is accepted, and it sets `sw_irq_o` to bit 0 of the write data.
- R6: A write to offset 0x4000 is accepted only with size 8. It stores all 64 data bits. A size-4 write there leaves the compare value unchanged.
- R7: A write to any other offset, or a write with a size its register does not accept, changes no state. It drives `err_o` high for exactly the one cycle after the write edge. The time count at 0xBFF8 is read-only.
- R8: Reset clears the time count, the cycle count, the software bit and `err_o`. It sets the compare value to all ones, so `timer_irq_o` is low.
- R9: A read returns the software bit at 0x0000, the compare value at 0x4000 and the time count at 0xBFF8, all combinationally. A size-4 read returns the low 32 bits zero-extended. Any other offset reads as zero.
- R10: When a compare write and a tick fall in the same cycle, the evaluation uses the newly written compare value and the incremented time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance the time and cycle counts this cycle |
| addr_i | input | 16 | Byte offset inside the unit window |
| size_i | input | 4 | Access size in bytes (4 or 8) |
| wdata_i | input | 64 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 64 | Read data for `addr_i` and `size_i` |
| err_o | output | 1 | One-cycle error after a rejected write |
| cycles_o | output | 64 | Cycle count |
| timer_irq_o | output | 1 | Machine timer interrupt pending |
| sw_irq_o | output | 1 | Machine software interrupt pending |

## Verification
A compare write and a tick can land on the same edge. The evaluation must then use the new deadline and the incremented time together. The bench freezes the time count and writes a deadline equal to the current time while holding `tick_i` high. It then expects `timer_irq_o` high right after that edge, because using either the stale time or the stale deadline would leave the line low. A second scenario checks the write-only path with the tick held low. There, the line must follow a deadline written one below the frozen time with no tick at all.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SW,
    SEL_CMP,
    SEL_TIME
  } reg_sel_e;
endpackage

// File: rtl/ctu_decode.sv
module ctu_decode
  import ctu_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned SZW      = 4,
  parameter logic [AW-1:0] SW_OFS   = 'h0000,
  parameter logic [AW-1:0] CMP_OFS  = 'h4000,
  parameter logic [AW-1:0] TIME_OFS = 'hBFF8
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic           we_i,
  output reg_sel_e       sel_o,
  output logic           sw_wr_o,
  output logic           cmp_wr_o,
  output logic           wr_bad_o
);
  localparam logic [SZW-1:0] SZ4 = SZW'(4);
  localparam logic [SZW-1:0] SZ8 = SZW'(8);

  logic size_word_ok, size_dbl_ok;

  always_comb begin
    if (addr_i == SW_OFS)        sel_o = SEL_SW;
    else if (addr_i == CMP_OFS)  sel_o = SEL_CMP;
    else if (addr_i == TIME_OFS) sel_o = SEL_TIME;
    else                         sel_o = SEL_NONE;
  end

  assign size_word_ok = (size_i == SZ4) || (size_i == SZ8);
  assign size_dbl_ok  = (size_i == SZ8);

  assign sw_wr_o  = we_i && (sel_o == SEL_SW)  && size_word_ok;
  assign cmp_wr_o = we_i && (sel_o == SEL_CMP) && size_dbl_ok;
  assign wr_bad_o = we_i && !sw_wr_o && !cmp_wr_o;
endmodule

// File: rtl/ctu_counters.sv
module ctu_counters #(
  parameter int unsigned TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [TW-1:0] time_q_o,
  output logic [TW-1:0] time_nxt_o,
  output logic [TW-1:0] cyc_q_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  assign time_nxt_o = tick_i ? time_q_o + ONE : time_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q_o <= '0;
      cyc_q_o  <= '0;
    end else if (tick_i) begin
      time_q_o <= time_nxt_o;
      cyc_q_o  <= cyc_q_o + ONE;
    end
  end
endmodule

// File: rtl/ctu_compare.sv
module ctu_compare #(
  parameter int unsigned TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cmp_wr_i,
  input  logic          sw_wr_i,
  input  logic [TW-1:0] wdata_i,
  input  logic [TW-1:0] time_nxt_i,
  output logic [TW-1:0] cmp_q_o,
  output logic          pend_q_o
);
  logic [TW-1:0] cmp_nxt;
  logic          eval, pend_nxt;

  assign cmp_nxt  = cmp_wr_i ? wdata_i : cmp_q_o;
  assign eval     = tick_i || cmp_wr_i || sw_wr_i;
  // strict unsigned below-time test; zero deadline disarms
  assign pend_nxt = (cmp_nxt != '0) && (cmp_nxt < time_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q_o  <= '1;
      pend_q_o <= 1'b0;
    end else begin
      cmp_q_o <= cmp_nxt;
      if (eval) pend_q_o <= pend_nxt;
    end
  end
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
  import ctu_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 64,
  parameter int unsigned SZW      = 4,
  parameter logic [AW-1:0] SW_OFS   = 'h0000,
  parameter logic [AW-1:0] CMP_OFS  = 'h4000,
  parameter logic [AW-1:0] TIME_OFS = 'hBFF8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [15:0]    addr_i,
  input  logic [3:0]     size_i,
  input  logic [63:0]    wdata_i,
  input  logic           we_i,
  output logic [63:0]    rdata_o,
  output logic           err_o,
  output logic [63:0]    cycles_o,
  output logic           timer_irq_o,
  output logic           sw_irq_o
);
  localparam int unsigned HW = DW / 2;
  localparam logic [SZW-1:0] SZ4 = SZW'(4);

  reg_sel_e      sel;
  logic          sw_wr, cmp_wr, wr_bad;
  logic [DW-1:0] time_q, time_nxt, cyc_q, cmp_q, rd_full;
  logic          sw_q, pend_q, err_q;

  ctu_decode #(
    .AW(AW), .SZW(SZW), .SW_OFS(SW_OFS), .CMP_OFS(CMP_OFS), .TIME_OFS(TIME_OFS)
  ) u_dec (
    .addr_i  (addr_i),
    .size_i  (size_i),
    .we_i    (we_i),
    .sel_o   (sel),
    .sw_wr_o (sw_wr),
    .cmp_wr_o(cmp_wr),
    .wr_bad_o(wr_bad)
  );

  ctu_counters #(.TW(DW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .time_q_o  (time_q),
    .time_nxt_o(time_nxt),
    .cyc_q_o   (cyc_q)
  );

  ctu_compare #(.TW(DW)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cmp_wr_i  (cmp_wr),
    .sw_wr_i   (sw_wr),
    .wdata_i   (wdata_i),
    .time_nxt_i(time_nxt),
    .cmp_q_o   (cmp_q),
    .pend_q_o  (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sw_wr) sw_q <= wdata_i[0];
      err_q <= wr_bad;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_SW:   rd_full = {{(DW-1){1'b0}}, sw_q};
      SEL_CMP:  rd_full = cmp_q;
      SEL_TIME: rd_full = time_q;
      default:  rd_full = '0;
    endcase
  end

  assign rdata_o     = (size_i == SZ4) ? {{HW{1'b0}}, rd_full[HW-1:0]} : rd_full;
  assign err_o       = err_q;
  assign cycles_o    = cyc_q;
  assign timer_irq_o = pend_q;
  assign sw_irq_o    = sw_q;
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
  parameter int unsigned DW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          we_i,
  input logic          sw_wr,
  input logic          cmp_wr,
  input logic          err_o,
  input logic          timer_irq_o,
  input logic [DW-1:0] time_q,
  input logic [DW-1:0] cyc_q,
  input logic [DW-1:0] cmp_q
);
  // R1
  a_r1_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (time_q == $past(time_q) + 1'b1) && (cyc_q == $past(cyc_q) + 1'b1));
  a_r1_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_q) && $stable(cyc_q));
  // R2, R4
  a_r2_pend_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_irq_o == ((cmp_q != '0) && (cmp_q < time_q)));
  // R3
  a_r3_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == '0) |-> !timer_irq_o);
  // R6
  a_r6_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr |=> $stable(cmp_q));
  // R7
  a_r7_err_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sw_wr && !cmp_wr) |=> err_o);
  a_r7_err_only_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !sw_wr && !cmp_wr) |=> !err_o);
endmodule

bind core_timer_unit ctu_checker #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .we_i       (we_i),
  .sw_wr      (sw_wr),
  .cmp_wr     (cmp_wr),
  .err_o      (err_o),
  .timer_irq_o(timer_irq_o),
  .time_q     (time_q),
  .cyc_q      (cyc_q),
  .cmp_q      (cmp_q)
);

// File: tb/sim_core_timer_unit.sv
`timescale 1ns/1ps
module sim_core_timer_unit;
  localparam logic [15:0] A_SW   = 16'h0000;
  localparam logic [15:0] A_CMP  = 16'h4000;
  localparam logic [15:0] A_TIME = 16'hBFF8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [3:0]  size_i = 4'd8;
  logic [63:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [63:0] rdata_o, cycles_o;
  logic        err_o, timer_irq_o, sw_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_time = '0;

  always #2 clk = ~clk;

  core_timer_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o),
    .err_o(err_o), .cycles_o(cycles_o), .timer_irq_o(timer_irq_o),
    .sw_irq_o(sw_irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of bus/tick activity, results visible at the following negedge
  task automatic cyc(input logic we, input logic [15:0] a, input logic [3:0] sz,
                     input logic [63:0] d, input logic tk);
    @(negedge clk);
    we_i = we; addr_i = a; size_i = sz; wdata_i = d; tick_i = tk;
    @(negedge clk);
    we_i = 1'b0; tick_i = 1'b0;
    if (tk) exp_time = exp_time + 1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] sz, output logic [63:0] v);
    addr_i = a; size_i = sz;
    #1;
    v = rdata_o;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R8 irq", {63'b0, timer_irq_o}, 64'd0);
    chk("R8 sw", {63'b0, sw_irq_o}, 64'd0);
    chk("R8 err", {63'b0, err_o}, 64'd0);
    chk("R8 cycles", cycles_o, 64'd0);
    rd(A_TIME, 4'd8, v); chk("R8 time", v, 64'd0);
    rd(A_CMP, 4'd8, v);  chk("R8 cmp", v, '1);
  endtask

  task automatic t_ticks();
    logic [63:0] v;
    for (int i = 0; i < 10; i++) cyc(1'b0, A_SW, 4'd8, 64'd0, 1'b1);
    rd(A_TIME, 4'd8, v); chk("R1 time", v, exp_time);
    chk("R1 cycles", cycles_o, exp_time);
    for (int i = 0; i < 3; i++) cyc(1'b0, A_SW, 4'd8, 64'd0, 1'b0);
    rd(A_TIME, 4'd8, v); chk("R1 hold time", v, exp_time);
    chk("R1 hold cycles", cycles_o, exp_time);
  endtask

  task automatic t_strict();
    cyc(1'b1, A_CMP, 4'd8, exp_time, 1'b0);
    chk("R2 equal", {63'b0, timer_irq_o}, 64'd0);
    cyc(1'b1, A_CMP, 4'd8, exp_time - 1, 1'b0);
    chk("R4 write eval", {63'b0, timer_irq_o}, 64'd1);
    cyc(1'b1, A_CMP, 4'd8, 64'h8000_0000_0000_0000, 1'b0);
    chk("R2 unsigned", {63'b0, timer_irq_o}, 64'd0);
    cyc(1'b1, A_CMP, 4'd8, exp_time - 1, 1'b0);
    cyc(1'b1, A_CMP, 4'd8, 64'd0, 1'b0);
    chk("R3 zero", {63'b0, timer_irq_o}, 64'd0);
    for (int i = 0; i < 5; i++) cyc(1'b0, A_SW, 4'd8, 64'd0, 1'b1);
    chk("R3 zero ticks", {63'b0, timer_irq_o}, 64'd0);
  endtask

  task automatic t_sw();
    cyc(1'b1, A_SW, 4'd4, 64'd3, 1'b0);
    chk("R5 size4 set", {63'b0, sw_irq_o}, 64'd1);
    cyc(1'b1, A_SW, 4'd8, 64'd2, 1'b0);
    chk("R5 size8 clr", {63'b0, sw_irq_o}, 64'd0);
    cyc(1'b1, A_SW, 4'd2, 64'd1, 1'b0);
    chk("R7 bad size err", {63'b0, err_o}, 64'd1);
    chk("R7 bad size sw", {63'b0, sw_irq_o}, 64'd0);
    cyc(1'b0, A_SW, 4'd8, 64'd0, 1'b0);
    chk("R7 err one cycle", {63'b0, err_o}, 64'd0);
  endtask

  task automatic t_cmp_size();
    logic [63:0] v;
    cyc(1'b1, A_CMP, 4'd8, 64'hFFFF_0000_0000_0064, 1'b0);
    chk("R6 no err", {63'b0, err_o}, 64'd0);
    cyc(1'b1, A_CMP, 4'd4, 64'd5, 1'b0);
    chk("R6 size4 err", {63'b0, err_o}, 64'd1);
    rd(A_CMP, 4'd8, v); chk("R6 cmp kept", v, 64'hFFFF_0000_0000_0064);
  endtask

  task automatic t_unmapped();
    logic [63:0] v;
    cyc(1'b1, A_TIME, 4'd8, 64'd0, 1'b0);
    chk("R7 time wr err", {63'b0, err_o}, 64'd1);
    rd(A_TIME, 4'd8, v); chk("R7 time kept", v, exp_time);
    cyc(1'b1, 16'h1234, 4'd8, 64'd1, 1'b0);
    chk("R7 unmapped err", {63'b0, err_o}, 64'd1);
    chk("R7 unmapped sw", {63'b0, sw_irq_o}, 64'd0);
  endtask

  task automatic t_read();
    logic [63:0] v;
    cyc(1'b1, A_CMP, 4'd8, 64'h1234_5678_9ABC_DEF0, 1'b0);
    rd(A_CMP, 4'd4, v); chk("R9 low word", v, 64'h0000_0000_9ABC_DEF0);
    rd(A_CMP, 4'd8, v); chk("R9 full", v, 64'h1234_5678_9ABC_DEF0);
    rd(16'h2000, 4'd8, v); chk("R9 unmapped", v, 64'd0);
    cyc(1'b1, A_SW, 4'd8, 64'd1, 1'b0);
    rd(A_SW, 4'd4, v); chk("R9 sw read", v, 64'd1);
  endtask

  task automatic t_same_cycle();
    logic [63:0] v;
    cyc(1'b1, A_CMP, 4'd8, exp_time, 1'b1);
    chk("R10 write+tick", {63'b0, timer_irq_o}, 64'd1);
    rd(A_TIME, 4'd8, v); chk("R10 time", v, exp_time);
    chk("R10 cycles", cycles_o, exp_time);
  endtask

  initial begin : watchdog
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ticks();
    t_strict();
    t_sw();
    t_cmp_size();
    t_unmapped();
    t_read();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule